// File: doc/BRIEF.md
# Four-Lane Pixel Serializer Across a 1:4 Clock Pair

The block accepts a group of pixels, one per lane, on each cycle of a slow acquisition clock. It hands them out one pixel per cycle on a processing clock that runs four times faster and is derived from the slow clock. Every lane has its own small dual-clock FIFO, so no storage element ever takes more than one write per slow cycle. The read side visits the lanes in a fixed rotation, starting at lane 0 and wrapping after the last lane. This rotation rebuilds the original pixel order on the fast clock.

A read attempt happens on every fast cycle in which `out_ready` is high. If the lane the rotation points to holds a pixel, that pixel is read out and the rotation moves on to the next lane. If that lane is empty, the attempt is counted as a timeout and the rotation stays where it is. The slow side drops a whole group when any lane is full, and raises a flag that stays set. Three counters let the user check that nothing was lost: pixels written, pixels read and timed-out attempts.

Top module: `mlane_serializer`

## Requirements
- R1: Pixels leave in arrival order. Within a group, the pixel on lane 0 (bits [PIX_W-1:0] of `in_pix`) comes first and lane 3 (the highest field) comes last. Groups leave in the order they were written.
- R2: Suppose every lane holds data and `out_ready` stays high. Then one pixel is delivered on every fast cycle, with no gap.
- R3: Suppose `in_valid` is high while any lane FIFO is full. Then the whole group is dropped, and `overflow` rises and stays high until `wr_rst`. Groups written before the overflow are delivered unchanged.
- R4: `wr_count` rises by LANES for each accepted group and does not change for a dropped group.
- R5: `out_valid` is high exactly one fast cycle after each successful read, with the pixel on `out_pix`. `rd_count` rises by one per successful read.
- R6: A read attempt is a fast cycle with `out_ready` high. When the selected lane is empty, the attempt raises `timeout_count` by one, produces no `out_valid`, and does not advance the rotation. `rd_count + timeout_count` equals the number of attempts.
- R7: While `out_ready` is low, nothing is read. `rd_count` and `timeout_count` hold, and `out_valid` stays low.
- R8: `wr_rst` clears `wr_count` and `overflow`. `rd_rst` clears `rd_count`, `timeout_count`, `out_valid` and the rotation index, which returns to lane 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Slow acquisition clock |
| wr_rst | input | 1 | Synchronous active-high reset, write domain |
| in_valid | input | 1 | A pixel group is presented |
| in_pix | input | LANES*PIX_W | Pixel group, lane n at bits [n*PIX_W +: PIX_W] |
| overflow | output | 1 | Sticky: a group was dropped |
| wr_count | output | CNT_W | Pixels accepted |
| rd_clk | input | 1 | Fast processing clock, four times wr_clk |
| rd_rst | input | 1 | Synchronous active-high reset, read domain |
| out_ready | input | 1 | Read attempt enable |
| out_valid | output | 1 | Pixel strobe |
| out_pix | output | PIX_W | Serialized pixel |
| rd_count | output | CNT_W | Pixels read |
| timeout_count | output | CNT_W | Attempts that found the selected lane empty |

## Verification
The bench builds the block with PIX_W=16, LANES=4, DEPTH=16 and CNT_W=32. A depth of 16 lets the bench fill every lane with just sixteen groups while the reader is held off. That puts the dropped seventeenth group and the sticky flag within a short run. Four lanes of 16 bits let each pixel carry its group and lane number, so any reordering or skipped lane shows up directly in the output stream. The fast clock is derived from the slow one by a divider, which keeps the exact 1:4 phase relation.

// File: rtl/mlane_pkg.sv
package mlane_pkg;
  function automatic logic [31:0] gray_to_bin(input logic [31:0] g);
    logic [31:0] b;
    b[31] = g[31];
    for (int i = 30; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  function automatic logic [31:0] bin_to_gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction
endpackage

// File: rtl/lane_fifo.sv
module lane_fifo #(
  parameter int PIX_W = 16,
  parameter int DEPTH = 16
) (
  input  logic             wr_clk,
  input  logic             wr_rst,
  input  logic             wr_en,
  input  logic [PIX_W-1:0] wr_data,
  output logic             full,
  input  logic             rd_clk,
  input  logic             rd_rst,
  input  logic             rd_en,
  output logic [PIX_W-1:0] rd_data,
  output logic             empty
);
  import mlane_pkg::*;
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  logic [PIX_W-1:0] mem [DEPTH];
  logic [PW-1:0] wr_bin, wr_gray, rd_bin, rd_gray;
  logic [PW-1:0] rg_s1, rg_s2, wg_s1, wg_s2;
  logic [PW-1:0] rd_bin_w, wr_bin_r;

  // write domain
  always_ff @(posedge wr_clk) begin
    if (wr_en) mem[wr_bin[AW-1:0]] <= wr_data;
  end

  always_ff @(posedge wr_clk) begin
    if (wr_rst) begin
      wr_bin  <= '0;
      wr_gray <= '0;
      rg_s1   <= '0;
      rg_s2   <= '0;
    end else begin
      rg_s1 <= rd_gray;
      rg_s2 <= rg_s1;
      if (wr_en) begin
        wr_bin  <= wr_bin + 1'b1;
        wr_gray <= PW'(bin_to_gray(32'(wr_bin + 1'b1)));
      end
    end
  end

  assign rd_bin_w = PW'(gray_to_bin(32'(rg_s2)));
  assign full     = (wr_bin - rd_bin_w) == PW'(DEPTH);

  // read domain
  always_ff @(posedge rd_clk) begin
    if (rd_rst) begin
      rd_bin  <= '0;
      rd_gray <= '0;
      wg_s1   <= '0;
      wg_s2   <= '0;
    end else begin
      wg_s1 <= wr_gray;
      wg_s2 <= wg_s1;
      if (rd_en) begin
        rd_bin  <= rd_bin + 1'b1;
        rd_gray <= PW'(bin_to_gray(32'(rd_bin + 1'b1)));
      end
    end
  end

  always_ff @(posedge rd_clk) begin
    if (rd_en) rd_data <= mem[rd_bin[AW-1:0]];
  end

  assign wr_bin_r = PW'(gray_to_bin(32'(wg_s2)));
  assign empty    = (rd_bin == wr_bin_r);

  // R3: the group gate upstream never writes a full lane
  a_r3_no_write_full: assert property (@(posedge wr_clk) disable iff (wr_rst)
    wr_en |-> !full);
  // R6: the reader never pops an empty lane
  a_r6_no_read_empty: assert property (@(posedge rd_clk) disable iff (rd_rst)
    rd_en |-> !empty);
  a_gray_one_step: assert property (@(posedge wr_clk) disable iff (wr_rst)
    $countones(wr_gray ^ $past(wr_gray)) <= 1);
endmodule

// File: rtl/lane_reader.sv
module lane_reader #(
  parameter int LANES = 4,
  parameter int CNT_W = 32
) (
  input  logic             rd_clk,
  input  logic             rd_rst,
  input  logic             out_ready,
  input  logic [LANES-1:0] lane_empty,
  output logic [LANES-1:0] lane_rd,
  output logic [$clog2(LANES)-1:0] sel_q,
  output logic             out_valid,
  output logic [CNT_W-1:0] rd_count,
  output logic [CNT_W-1:0] timeout_count
);
  localparam int IW = $clog2(LANES);

  logic [IW-1:0] idx;
  logic          hit, miss;

  assign hit  = out_ready && !lane_empty[idx];
  assign miss = out_ready &&  lane_empty[idx];

  always_comb begin
    lane_rd = '0;
    lane_rd[idx] = hit;
  end

  always_ff @(posedge rd_clk) begin
    if (rd_rst) begin
      idx           <= '0;
      sel_q         <= '0;
      out_valid     <= 1'b0;
      rd_count      <= '0;
      timeout_count <= '0;
    end else begin
      out_valid <= hit;
      if (hit) begin
        sel_q    <= idx;
        idx      <= (idx == IW'(LANES-1)) ? '0 : idx + 1'b1;
        rd_count <= rd_count + 1'b1;
      end
      if (miss) timeout_count <= timeout_count + 1'b1;
    end
  end

  // R6: an empty selected lane holds the rotation
  a_r6_hold_on_miss: assert property (@(posedge rd_clk) disable iff (rd_rst)
    (out_ready && lane_empty[idx]) |=> $stable(idx));
  // R7: no strobe without a preceding attempt
  a_r7_valid_needs_ready: assert property (@(posedge rd_clk) disable iff (rd_rst)
    out_valid |-> $past(out_ready));
  a_r5_single_pop: assert property (@(posedge rd_clk) disable iff (rd_rst)
    $onehot0(lane_rd));
endmodule

// File: rtl/mlane_serializer.sv
module mlane_serializer #(
  parameter int PIX_W = 16,
  parameter int LANES = 4,
  parameter int DEPTH = 16,
  parameter int CNT_W = 32
) (
  input  logic                   wr_clk,
  input  logic                   wr_rst,
  input  logic                   in_valid,
  input  logic [LANES*PIX_W-1:0] in_pix,
  output logic                   overflow,
  output logic [CNT_W-1:0]       wr_count,
  input  logic                   rd_clk,
  input  logic                   rd_rst,
  input  logic                   out_ready,
  output logic                   out_valid,
  output logic [PIX_W-1:0]       out_pix,
  output logic [CNT_W-1:0]       rd_count,
  output logic [CNT_W-1:0]       timeout_count
);
  localparam int IW = $clog2(LANES);

  logic [LANES-1:0] lane_full, lane_empty, lane_rd;
  logic [PIX_W-1:0] lane_q [LANES];
  logic [IW-1:0]    sel_q;
  logic             accept;

  assign accept = in_valid && !(|lane_full);

  always_ff @(posedge wr_clk) begin
    if (wr_rst) begin
      overflow <= 1'b0;
      wr_count <= '0;
    end else begin
      if (in_valid && (|lane_full)) overflow <= 1'b1;
      if (accept) wr_count <= wr_count + CNT_W'(LANES);
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    lane_fifo #(.PIX_W(PIX_W), .DEPTH(DEPTH)) fifo_i (
      .wr_clk (wr_clk),
      .wr_rst (wr_rst),
      .wr_en  (accept),
      .wr_data(in_pix[g*PIX_W +: PIX_W]),
      .full   (lane_full[g]),
      .rd_clk (rd_clk),
      .rd_rst (rd_rst),
      .rd_en  (lane_rd[g]),
      .rd_data(lane_q[g]),
      .empty  (lane_empty[g])
    );
  end

  lane_reader #(.LANES(LANES), .CNT_W(CNT_W)) reader_i (
    .rd_clk       (rd_clk),
    .rd_rst       (rd_rst),
    .out_ready    (out_ready),
    .lane_empty   (lane_empty),
    .lane_rd      (lane_rd),
    .sel_q        (sel_q),
    .out_valid    (out_valid),
    .rd_count     (rd_count),
    .timeout_count(timeout_count)
  );

  assign out_pix = lane_q[sel_q];

  // R3: once set, the drop flag holds until write reset
  a_r3_overflow_sticky: assert property (@(posedge wr_clk) disable iff (wr_rst)
    overflow |=> overflow);
  // R4: a dropped group leaves the write count alone
  a_r4_drop_no_count: assert property (@(posedge wr_clk) disable iff (wr_rst)
    (in_valid && (|lane_full)) |=> $stable(wr_count));
endmodule

// File: tb/mlane_serializer_tb_top.sv
module mlane_serializer_tb_top;
  localparam int PW = 16;
  localparam int NL = 4;

  logic rd_clk = 1'b0;
  logic [1:0] div = 2'd0;
  logic wr_clk;
  logic wr_rst = 1'b1, rd_rst = 1'b1;
  logic in_valid = 1'b0;
  logic [NL*PW-1:0] in_pix = '0;
  logic out_ready = 1'b0;
  logic overflow, out_valid;
  logic [PW-1:0] out_pix;
  logic [31:0] wr_count, rd_count, timeout_count;

  always #4 rd_clk = ~rd_clk;
  always @(posedge rd_clk) div <= div + 2'd1;
  assign wr_clk = div[1];

  mlane_serializer #(.PIX_W(PW), .LANES(NL), .DEPTH(16), .CNT_W(32)) dut_i (
    .wr_clk(wr_clk), .wr_rst(wr_rst), .in_valid(in_valid), .in_pix(in_pix),
    .overflow(overflow), .wr_count(wr_count),
    .rd_clk(rd_clk), .rd_rst(rd_rst), .out_ready(out_ready),
    .out_valid(out_valid), .out_pix(out_pix),
    .rd_count(rd_count), .timeout_count(timeout_count));

  localparam logic [63:0] VEC [0:7] = '{
    64'h0003_0002_0001_0000, 64'hFFFF_0000_FFFF_0000,
    64'h1234_5678_9ABC_DEF0, 64'hAAAA_5555_AAAA_5555,
    64'h8000_4000_2000_1000, 64'h0F0F_F0F0_00FF_FF00,
    64'hDEAD_BEEF_CAFE_F00D, 64'h7777_6666_5555_4444};

  int total = 0, bad = 0;
  int cyc = 0, attempts = 0;
  int got_n = 0;
  logic [PW-1:0] got [0:127];
  int stamp [0:127];

  always @(posedge rd_clk) begin
    cyc <= cyc + 1;
    if (!rd_rst && out_ready) attempts <= attempts + 1;
  end

  always @(negedge rd_clk) begin
    if (out_valid && got_n < 128) begin
      got[got_n]   = out_pix;
      stamp[got_n] = cyc;
      got_n        = got_n + 1;
    end
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [63:0] d);
    @(posedge wr_clk); #1;
    in_valid = 1'b1;
    in_pix   = d;
  endtask

  task automatic push_end();
    @(posedge wr_clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic rd_wait(input int n);
    repeat (n) @(posedge rd_clk);
    #1;
  endtask

  initial begin
    repeat (400000) @(posedge rd_clk);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int base_wr, base_rd, base_to, k;
    logic [63:0] g;
    rd_wait(16);
    wr_rst = 1'b0; rd_rst = 1'b0;
    rd_wait(4);
    // R8: reset state
    check("R8 wr_count", wr_count, 0);
    check("R8 overflow", overflow, 0);
    check("R8 rd_count", rd_count, 0);
    check("R8 timeout_count", timeout_count, 0);
    check("R8 out_valid", out_valid, 0);

    // table walk: write all groups with reader idle
    for (int v = 0; v < 8; v++) push(VEC[v]);
    push_end();
    rd_wait(24);
    check("R4 wr_count after table", wr_count, 32);
    check("R7 no read while not ready", rd_count, 0);
    check("R7 no timeout while not ready", timeout_count, 0);
    check("R7 no strobe while not ready", got_n, 0);
    @(posedge rd_clk); #1; out_ready = 1'b1;
    rd_wait(40);
    check("R5 rd_count table", rd_count, 32);
    check("R5 pixel count", got_n, 32);
    for (int i = 0; i < 32; i++) begin
      g = VEC[i/4];
      check("R1 order", got[i], g[(i%4)*PW +: PW]);
    end
    check("R2 back-to-back span", stamp[31] - stamp[0], 31);
    check("R6 sum of attempts", rd_count + timeout_count, attempts);

    // R6: exact timeouts on empty lanes
    @(posedge rd_clk); #1; out_ready = 1'b0;
    rd_wait(3);
    base_rd = rd_count; base_to = timeout_count; k = got_n;
    out_ready = 1'b1;
    rd_wait(5);
    out_ready = 1'b0;
    rd_wait(3);
    check("R6 timeout step", timeout_count - base_to, 5);
    check("R6 no read on empty", rd_count - base_rd, 0);
    check("R6 no strobe on empty", got_n - k, 0);
    check("R7 counts hold", timeout_count - base_to, 5);

    // R3: fill lanes, seventeenth group dropped
    base_wr = wr_count; got_n = 0;
    for (int gi = 0; gi < 16; gi++)
      push({16'hA000 + 16'(gi*16+3), 16'hA000 + 16'(gi*16+2),
            16'hA000 + 16'(gi*16+1), 16'hA000 + 16'(gi*16)});
    push_end();
    rd_wait(8);
    check("R3 no overflow at full", overflow, 0);
    push({16'hB003, 16'hB002, 16'hB001, 16'hB000});
    push_end();
    rd_wait(8);
    check("R3 overflow set", overflow, 1);
    check("R4 drop not counted", wr_count - base_wr, 64);
    @(posedge rd_clk); #1; out_ready = 1'b1;
    rd_wait(90);
    out_ready = 1'b0;
    rd_wait(4);
    check("R3 kept pixel count", got_n, 64);
    check("R3 last kept pixel", got[63], 16'hA0F3);
    check("R1 first after fill", got[0], 16'hA000);
    check("R3 overflow still held", overflow, 1);

    // R8: resets clear everything again
    wr_rst = 1'b1; rd_rst = 1'b1;
    rd_wait(12);
    wr_rst = 1'b0; rd_rst = 1'b0;
    rd_wait(4);
    check("R8 overflow cleared", overflow, 0);
    check("R8 wr_count cleared", wr_count, 0);
    check("R8 rd_count cleared", rd_count, 0);
    check("R8 timeout cleared", timeout_count, 0);
    // rotation back at lane 0: one group gives lane 0 first
    got_n = 0;
    push(64'h0044_0033_0022_0011);
    push_end();
    rd_wait(12);
    out_ready = 1'b1;
    rd_wait(10);
    out_ready = 1'b0;
    rd_wait(3);
    check("R8 rotation at lane 0", got[0], 16'h0011);
    check("R1 lane 3 last", got[3], 16'h0044);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule